// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. It serves four sources. The first is an external input pin, which raises a request on its high-to-low transition. The other three are a timer overflow pulse, an analog-to-digital conversion-done pulse and a pulse from an I2C peripheral, which fires on an address match or at the end of a byte. Each source has a request flag and an enable bit. These bits sit in two byte-wide control registers, together with one global enable. Software can read and write both registers.

Requests are looked at only on cycles marked by the core's sampling phase strobe. A request that arrives between two strobes is therefore taken at the next strobe. A source is eligible when four things hold: its flag is set, its own enable is set, the global enable is set, and the return stack is not full. When sources are eligible, the one with the lowest index wins.

On acceptance the controller does three things for one cycle. It raises an acknowledge and a push request for the program counter, and it drives the fixed vector of the winning source. In the same cycle it clears the taken flag and the global enable. A return-from-interrupt sets the global enable again; a plain return does not. A wake-up output is high while any enabled source has its flag set.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, `irq_ack` is 0 and `wake` is 0.
- R2: A 1-to-0 change of `ext_pin` sets the external flag (register 0 bit 4) at the first clock edge that samples the pin low. A pin held low, or rising, sets nothing.
- R3: A one-cycle pulse on `tmr_ovf`, `adc_done` or `i2c_evt` sets, respectively, register 0 bit 5, register 0 bit 6 or register 1 bit 4.
- R4: Register 0 holds the global enable in bit 0, the external, timer and ADC enables in bits 1 to 3, and the flags in bits 4 to 6. Bit 7 reads 0. Register 1 holds the I2C enable in bit 0 and the I2C flag in bit 4. All its other bits read 0, so writing 0xFF reads back 0x7F and 0x11.
- R5: An acknowledge occurs only in a cycle where all of these hold: `sample_en` is 1, `stack_full` is 0, the global enable is 1, and some source has both its flag and its enable set.
- R6: Vectors are 0x04 for external, 0x08 for timer, 0x0C for ADC and 0x10 for I2C, in that priority order with external highest. `irq_vector` is 0x00 when there is no acknowledge.
- R7: `irq_ack` and `push_req` are high for exactly one cycle. At that edge the taken flag and the global enable clear, and all other flags are kept.
- R8: A return with `ret_reti`=1 sets the global enable. A return with `ret_reti`=0 leaves it unchanged.
- R9: A hardware set of a flag wins over a software write and over an acceptance clear of that flag in the same cycle.
- R10: A flag stays set until it is serviced or software writes it to 0.
- R11: `wake` is 1 exactly when some source has both its flag and its own enable set, whatever the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External interrupt pin (falling edge) |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | Conversion-done pulse |
| i2c_evt | input | 1 | I2C address-match or byte-done pulse |
| sample_en | input | 1 | Sampling phase strobe; requests are taken only when 1 |
| stack_full | input | 1 | Return stack has no free entry |
| reg_wr | input | 1 | Software write strobe |
| reg_sel | input | 1 | Register select: 0 = register 0, 1 = register 1 |
| reg_wdata | input | 8 | Software write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ret_valid | input | 1 | Return instruction executes this cycle |
| ret_reti | input | 1 | The return is a return-from-interrupt |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| push_req | output | 1 | Push the program counter onto the stack |
| irq_vector | output | 8 | Branch address of the accepted source |
| wake | output | 1 | Wake-up request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a hardware flag set and a software write to the same register. The second is a hardware flag set and the acceptance of that same source, which would otherwise clear its flag. The bench provokes the first by pulsing `tmr_ovf` in the cycle where software writes register 0 with 0x00, and the second by pulsing `tmr_ovf` in the cycle the timer request is acknowledged. In both cases it judges the outcome by reading the registers afterwards: the timer flag must still be set. After the acceptance the global enable must also be clear. Priority is tested by setting several flags together and unwinding them one acceptance and one return-from-interrupt at a time. A scoreboard compares each acknowledged vector with the expected sequence.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
    localparam int NSRC      = 4;
    localparam int IDX_W     = $clog2(NSRC);
    localparam int REG_W     = 8;
    localparam int R0_SRCS   = 3;              // sources living in register 0
    localparam int R0_GE_BIT = 0;
    localparam int R0_EN_LO  = 1;
    localparam int R0_FL_LO  = 4;
    localparam int R1_EN_BIT = 0;
    localparam int R1_FL_BIT = 4;
    localparam logic [REG_W-1:0] VEC_BASE = 8'h04;
    localparam int VEC_STEP  = 4;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT = 2'd0,
        SRC_TMR = 2'd1,
        SRC_ADC = 2'd2,
        SRC_I2C = 2'd3
    } src_e;

    typedef struct packed {
        logic            ge;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
    } irq_state_t;

    function automatic logic [REG_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [REG_W-1:0] v;
        v = VEC_BASE + REG_W'(idx) * REG_W'(VEC_STEP);
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_r0(input irq_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[R0_GE_BIT] = s.ge;
        for (int i = 0; i < R0_SRCS; i++) begin
            r[R0_EN_LO + i] = s.en[i];
            r[R0_FL_LO + i] = s.flag[i];
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_r1(input irq_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[R1_EN_BIT] = s.en[SRC_I2C];
        r[R1_FL_BIT] = s.flag[SRC_I2C];
        return r;
    endfunction
endpackage

// File: rtl/irq_edge_fall.sv
`timescale 1ns/1ps
module irq_edge_fall (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic prev_q;

    // Reset value 0 keeps a pin already low at reset from looking like an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin;
    end

    assign fall = prev_q & ~pin;
endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
module irq_prio_arb
    import irq_pkg::*;
(
    input  logic [NSRC-1:0]  req,
    output logic [NSRC-1:0]  grant,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_grant
            if (g == 0) begin : g_top
                assign grant[g] = req[g];
            end else begin : g_low
                assign grant[g] = req[g] & ~(|req[g-1:0]);
            end
        end
    endgenerate

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  hw_set,
    input  logic             wr,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             accept,
    input  logic [NSRC-1:0]  taken,
    input  logic             ret_valid,
    input  logic             ret_reti,
    output irq_state_t       st
);
    irq_state_t st_q;
    logic wr0, wr1;

    assign wr0 = wr & ~sel;
    assign wr1 = wr &  sel;

    // Global enable: acceptance clear beats return-from-interrupt beats write.
    always_ff @(posedge clk) begin
        if (rst)                        st_q.ge <= 1'b0;
        else if (accept)                st_q.ge <= 1'b0;
        else if (ret_valid && ret_reti) st_q.ge <= 1'b1;
        else if (wr0)                   st_q.ge <= wdata[R0_GE_BIT];
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            logic hit;
            logic wen_bit, wfl_bit;
            if (g < R0_SRCS) begin : g_r0
                assign hit     = wr0;
                assign wen_bit = wdata[R0_EN_LO + g];
                assign wfl_bit = wdata[R0_FL_LO + g];
            end else begin : g_r1
                assign hit     = wr1;
                assign wen_bit = wdata[R1_EN_BIT];
                assign wfl_bit = wdata[R1_FL_BIT];
            end

            always_ff @(posedge clk) begin
                if (rst)      st_q.en[g] <= 1'b0;
                else if (hit) st_q.en[g] <= wen_bit;
            end

            // Hardware set has the highest priority for every flag.
            always_ff @(posedge clk) begin
                if (rst)                      st_q.flag[g] <= 1'b0;
                else if (hw_set[g])           st_q.flag[g] <= 1'b1;
                else if (hit)                 st_q.flag[g] <= wfl_bit;
                else if (accept && taken[g])  st_q.flag[g] <= 1'b0;
            end
        end
    endgenerate

    assign st = st_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic             tmr_ovf,
    input  logic             adc_done,
    input  logic             i2c_evt,
    input  logic             sample_en,
    input  logic             stack_full,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             ret_valid,
    input  logic             ret_reti,
    output logic             irq_ack,
    output logic             push_req,
    output logic [7:0]       irq_vector,
    output logic             wake
);
    irq_state_t      st;
    logic            ext_fall;
    logic [NSRC-1:0] hw_set, pend, elig, grant;
    logic            any_elig, accept;
    logic [IDX_W-1:0] win_idx;
    logic [REG_W-1:0] r0_view, r1_view;

    irq_edge_fall u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pin),
        .fall (ext_fall)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[SRC_EXT] = ext_fall;
        hw_set[SRC_TMR] = tmr_ovf;
        hw_set[SRC_ADC] = adc_done;
        hw_set[SRC_I2C] = i2c_evt;
    end

    irq_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .hw_set    (hw_set),
        .wr        (reg_wr),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .accept    (accept),
        .taken     (grant),
        .ret_valid (ret_valid),
        .ret_reti  (ret_reti),
        .st        (st)
    );

    assign pend = st.flag & st.en;
    assign elig = pend & {NSRC{st.ge}};

    irq_prio_arb u_arb (
        .req   (elig),
        .grant (grant),
        .any   (any_elig),
        .idx   (win_idx)
    );

    assign accept     = sample_en & ~stack_full & any_elig;
    assign irq_ack    = accept;
    assign push_req   = accept;
    assign irq_vector = accept ? vec_of(win_idx) : '0;
    assign wake       = |pend;

    assign r0_view   = pack_r0(st);
    assign r1_view   = pack_r1(st);
    assign reg_rdata = reg_sel ? r1_view : r0_view;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
`timescale 1ns/1ps
module irq_vector_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ext_pin,
    input logic       tmr_ovf,
    input logic       sample_en,
    input logic       stack_full,
    input logic       ret_valid,
    input logic       ret_reti,
    input logic       irq_ack,
    input logic       push_req,
    input logic [7:0] irq_vector,
    input logic [7:0] r0,
    input logic [7:0] r1
);
    logic up_q;
    always_ff @(posedge clk) begin
        if (rst) up_q <= 1'b0;
        else     up_q <= 1'b1;
    end

    AST_ACK_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (sample_en && !stack_full && r0[0])); // R5
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (irq_vector inside {8'h04, 8'h08, 8'h0C, 8'h10})); // R6
    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !irq_ack |-> (irq_vector == 8'h00)); // R6
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack); // R7
    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (rst)
        irq_ack == push_req); // R7
    AST_GE_DROP: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !r0[0]); // R7
    AST_RETI_GE: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_reti && !irq_ack) |=> r0[0]); // R8
    AST_EXT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (up_q && $fell(ext_pin)) |=> r0[4]); // R2
    AST_HW_WINS: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> r0[5]); // R9
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!r0[7] && r1[7:5] == 3'b000 && r1[3:1] == 3'b000)); // R4
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_pin    (ext_pin),
    .tmr_ovf    (tmr_ovf),
    .sample_en  (sample_en),
    .stack_full (stack_full),
    .ret_valid  (ret_valid),
    .ret_reti   (ret_reti),
    .irq_ack    (irq_ack),
    .push_req   (push_req),
    .irq_vector (irq_vector),
    .r0         (r0_view),
    .r1         (r1_view)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/100ps
module irq_vector_ctrl_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst, ext_pin, tmr_ovf, adc_done, i2c_evt, sample_en, stack_full;
    logic reg_wr, reg_sel, ret_valid, ret_reti;
    logic [7:0] reg_wdata, reg_rdata, irq_vector;
    logic irq_ack, push_req, wake;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .adc_done(adc_done), .i2c_evt(i2c_evt), .sample_en(sample_en),
        .stack_full(stack_full), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ret_valid(ret_valid),
        .ret_reti(ret_reti), .irq_ack(irq_ack), .push_req(push_req),
        .irq_vector(irq_vector), .wake(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver side of the scoreboard.
    task automatic expect_vec(input int v);
        exp_q.push_back(v);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string req);
        reg_sel = sel;
        #0.5;
        chk(req, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic ret(input logic kind);
        ret_valid = 1'b1; ret_reti = kind;
        cyc();
        ret_valid = 1'b0; ret_reti = 1'b0;
    endtask

    // Monitor: samples one time unit after each falling edge.
    always @(negedge clk) begin
        #1;
        if (!rst && irq_ack) begin
            checks++;
            if (push_req !== 1'b1) begin
                errors++;
                $display("FAIL R7 push_req actual=%0b expected=1", push_req);
            end
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected ack actual=%0h expected=none", irq_vector);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(irq_vector) != e) begin
                    errors++;
                    $display("FAIL R6 vector actual=%0h expected=%0h", irq_vector, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ext_pin = 1'b0; tmr_ovf = 1'b0; adc_done = 1'b0; i2c_evt = 1'b0;
        sample_en = 1'b0; stack_full = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0;
        reg_wdata = 8'h00; ret_valid = 1'b0; ret_reti = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc();

        // R1 reset state
        rd(0, 8'h00, "R1 reg0");
        rd(1, 8'h00, "R1 reg1");
        chk("R1 ack", irq_ack, 0);
        chk("R1 wake", wake, 0);

        // R4 layout, R11 wake
        wr(0, 8'hFF);
        wr(1, 8'hFF);
        rd(0, 8'h7F, "R4 reg0 unused");
        rd(1, 8'h11, "R4 reg1 unused");
        chk("R11 wake pending", wake, 1);

        // R5 stack full blocks
        stack_full = 1'b1; sample_en = 1'b1;
        cyc();
        rd(0, 8'h7F, "R5 stack full no service");
        stack_full = 1'b0;

        // R6 priority unwinding, R7 clears, R8 return kinds
        expect_vec(8'h04);
        cyc();
        rd(0, 8'h6E, "R7 ext taken GE cleared");
        cyc();
        ret(1'b0);
        rd(0, 8'h6E, "R8 plain return keeps GE");
        expect_vec(8'h08);
        ret(1'b1);
        cyc();
        rd(0, 8'h4E, "R6 timer second");
        expect_vec(8'h0C);
        ret(1'b1);
        cyc();
        rd(0, 8'h0E, "R6 adc third");
        expect_vec(8'h10);
        ret(1'b1);
        cyc();
        rd(1, 8'h01, "R6 i2c last");
        ret(1'b1);
        rd(0, 8'h0F, "R8 reti sets GE");
        sample_en = 1'b0;

        // R2 falling edge
        wr(0, 8'h00);
        wr(1, 8'h00);
        ext_pin = 1'b1;
        cyc(2);
        ext_pin = 1'b0;
        cyc();
        rd(0, 8'h10, "R2 fall sets flag");
        wr(0, 8'h00);
        cyc(3);
        rd(0, 8'h00, "R2 held low no set");
        ext_pin = 1'b1;
        cyc(2);
        rd(0, 8'h00, "R2 rise no set");

        // R3 peripheral pulses
        tmr_ovf = 1'b1; cyc(); tmr_ovf = 1'b0;
        rd(0, 8'h20, "R3 timer");
        adc_done = 1'b1; cyc(); adc_done = 1'b0;
        rd(0, 8'h60, "R3 adc");
        i2c_evt = 1'b1; cyc(); i2c_evt = 1'b0;
        rd(1, 8'h10, "R3 i2c");

        // R10 persistence and software clear
        cyc(5);
        rd(0, 8'h60, "R10 flags persist");
        chk("R11 no wake when disabled", wake, 0);
        wr(1, 8'h00);
        rd(1, 8'h00, "R10 sw clear");

        // R9 hardware set vs software write
        reg_sel = 1'b0; reg_wdata = 8'h00; reg_wr = 1'b1; tmr_ovf = 1'b1;
        cyc();
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        rd(0, 8'h20, "R9 hw set beats write");

        // R5 own enable needed; R11
        wr(0, 8'h21);
        sample_en = 1'b1;
        cyc(2);
        sample_en = 1'b0;
        rd(0, 8'h21, "R5 disabled source not served");
        chk("R11 wake needs own enable", wake, 0);
        wr(0, 8'h25);
        chk("R11 wake enabled", wake, 1);
        cyc();
        rd(0, 8'h25, "R5 no strobe no service");

        // R9 hardware set vs acceptance clear
        expect_vec(8'h08);
        tmr_ovf = 1'b1; sample_en = 1'b1;
        cyc();
        tmr_ovf = 1'b0; sample_en = 1'b0;
        rd(0, 8'h24, "R9 hw set beats accept clear");

        // R6 simultaneous hardware requests
        wr(0, 8'h00);
        wr(1, 8'h01);
        wr(0, 8'h0F);
        adc_done = 1'b1; i2c_evt = 1'b1;
        cyc();
        adc_done = 1'b0; i2c_evt = 1'b0;
        expect_vec(8'h0C);
        sample_en = 1'b1;
        cyc();
        sample_en = 1'b0;
        rd(1, 8'h11, "R6 lower source still pending");
        expect_vec(8'h10);
        ret(1'b1);
        sample_en = 1'b1;
        cyc();
        sample_en = 1'b0;
        rd(1, 8'h01, "R7 i2c flag cleared");

        cyc(3);
        chk("R6 all expected vectors seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule